// File: doc/BRIEF.md
# Comparator Change Interrupt Controller

This block watches two asynchronous comparator outputs and raises a sticky flag whenever either output moves away from a stored reference value. Each comparator has its own reference bit. A flag is set only on the cycle in which the mismatch between the synchronized output and that reference first appears. A mismatch that simply persists sets nothing further. Software clears a flag by writing it, and can re-arm the reference by touching the comparator's control register.

Whether a comparator returning to its old level raises a new flag therefore depends on software. If the reference was not refreshed, the return only removes the mismatch and stays silent. If the reference was refreshed while the output was in the new state, the return is a fresh mismatch and is flagged.

Flags are always recorded. A single registered interrupt request forms only when a flag is set, that comparator's own enable is set, and both the peripheral enable and the global enable are set. Decoding the direction of a change is left to software, which can read the live output bit of each comparator.

Top module: `cmp_change_irq`

## Requirements
- R1: After reset, every flag, every enable, both reference bits and the interrupt request are 0. Reads of the flag register (address 0), the enable register (address 1) and the global register (address 2) all return 0x00.
- R2: When a comparator output differs from its reference for the first time, its flag is set: bit 3 of the flag register for comparator 0, bit 4 for comparator 1. The flag is visible three rising edges after the input changes, which is two synchronizer stages plus the flag register.
- R3: A write to the flag register loads bits 4:3 from the write data, so writing 0 clears a flag and writing 1 sets it. The other bits of that register read 0.
- R4: When a change event and a clearing write to the same flag fall on the same edge, the flag ends up set.
- R5: A set flag stays set until it is written. If the reference has not been refreshed, an output that returns to the reference level sets no new flag.
- R6: A read or a write of a comparator's control register loads that comparator's reference from its synchronized output. Comparator 0 is at address 3 and comparator 1 at address 4. A later return to the former level then sets the flag.
- R7: If a control-register access falls on the same edge at which a new mismatch would set the flag, no flag is set and the reference takes the new output value.
- R8: One edge after the condition holds, `irq_o` is 1 exactly when the global enable (address 2, bit 7), the peripheral enable (address 1, bit 6) and some flag together with its own enable (address 1, bits 3 and 4) are all set. Flags are set whatever the enables are.
- R9: The enable register reads back its writable bits, which are 6, 4 and 3, with every other bit 0. A control register reads the synchronized output of its comparator in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 2 | Raw comparator outputs, bit n for comparator n |
| rd_en_i | input | 1 | Read strobe; only affects control-register side effects |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A comparator change becomes a flag three rising edges after the input moves. The interrupt request follows one edge after that. Register writes take effect at the next edge, and read data is combinational. The bench therefore drives inputs on falling edges and waits four falling edges after every stimulus before it reads the flag register and `irq_o`. The same-edge cases (R4, R7) place the access strobe exactly over the third rising edge after the input change, which is the edge at which the flag would be written.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

    // Fixed register geometry of the peripheral bus.
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam addr_t ADDR_FLAGS    = 3'd0;
    localparam addr_t ADDR_ENABLE   = 3'd1;
    localparam addr_t ADDR_GLOBAL   = 3'd2;
    localparam addr_t ADDR_CTL_BASE = 3'd3;   // comparator n at base + n

    // Per-comparator change detector state.
    typedef struct packed {
        logic refv;   // stored reference level
        logic mis;    // mismatch seen on the previous cycle
    } edge_st_t;

endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cmpirq_edge.sv
module cmpirq_edge
    import cmpirq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmp_i,     // synchronized comparator level
    input  logic touch_i,   // control register accessed this cycle
    output logic set_o      // one-cycle change event
);

    edge_st_t st_d, st_q;
    logic     mismatch;

    always_comb begin
        mismatch = cmp_i ^ st_q.refv;
        st_d     = st_q;
        set_o    = 1'b0;
        if (touch_i) begin
            // Refresh wins over a same-cycle rise: reference absorbs it.
            st_d.refv = cmp_i;
            st_d.mis  = 1'b0;
        end else begin
            st_d.mis = mismatch;
            set_o    = mismatch & ~st_q.mis;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    ref_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        touch_i |=> (st_q.refv == $past(cmp_i)));

    // R2
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_o |=> !set_o);

endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
    import cmpirq_pkg::*;
#(
    parameter int unsigned N_CMP       = 2,
    parameter int unsigned FLAG_LSB    = 3,
    parameter int unsigned SRC_EN_LSB  = 3,
    parameter int unsigned PEIE_BIT    = 6,
    parameter int unsigned GIE_BIT     = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_CMP-1:0]  cmp_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int unsigned FLAG_MSB   = FLAG_LSB + N_CMP - 1;
    localparam int unsigned SRC_EN_MSB = SRC_EN_LSB + N_CMP - 1;

    typedef struct packed {
        logic [N_CMP-1:0] flag;
        logic [N_CMP-1:0] src_en;
        logic             peie;
        logic             gie;
        logic             irq;
    } regs_t;

    regs_t            st_d, st_q;
    logic [N_CMP-1:0] cmp_s;
    logic [N_CMP-1:0] set_vec;
    logic [N_CMP-1:0] touch;
    logic             wr_flags, wr_enable, wr_global;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i;

    cmpirq_sync #(
        .WIDTH (N_CMP),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(cmp_i),
        .sync_o (cmp_s)
    );

    always_comb begin
        for (int i = 0; i < int'(N_CMP); i++) begin
            touch[i] = (rd_en_i | wr_en_i) &&
                       (addr_i == addr_t'(int'(ADDR_CTL_BASE) + i));
        end
    end

    for (genvar g = 0; g < int'(N_CMP); g++) begin : g_cmp
        cmpirq_edge u_edge (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cmp_i  (cmp_s[g]),
            .touch_i(touch[g]),
            .set_o  (set_vec[g])
        );

        // R3
        flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_flags && !wdata_i[FLAG_LSB+g] && !set_vec[g]) |=> !st_q.flag[g]);

        // R4
        set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_vec[g] |=> st_q.flag[g]);

        // R5
        flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.flag[g] && !wr_flags) |=> st_q.flag[g]);

        // R7
        collision_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            touch[g] |-> !set_vec[g]);

        // R2
        flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(st_q.flag[g]) |->
                $past(set_vec[g] || (wr_flags && wdata_i[FLAG_LSB+g])));
    end

    always_comb begin
        wr_flags  = wr_en_i && (addr_i == ADDR_FLAGS);
        wr_enable = wr_en_i && (addr_i == ADDR_ENABLE);
        wr_global = wr_en_i && (addr_i == ADDR_GLOBAL);

        st_d = st_q;
        // A change event overrides a same-cycle software clear.
        st_d.flag = set_vec | (wr_flags ? wdata_i[FLAG_MSB:FLAG_LSB] : st_q.flag);
        if (wr_enable) begin
            st_d.src_en = wdata_i[SRC_EN_MSB:SRC_EN_LSB];
            st_d.peie   = wdata_i[PEIE_BIT];
        end
        if (wr_global) begin
            st_d.gie = wdata_i[GIE_BIT];
        end
        st_d.irq = st_q.gie & st_q.peie & (|(st_q.flag & st_q.src_en));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_FLAGS: rdata_o[FLAG_MSB:FLAG_LSB] = st_q.flag;
            ADDR_ENABLE: begin
                rdata_o[SRC_EN_MSB:SRC_EN_LSB] = st_q.src_en;
                rdata_o[PEIE_BIT]              = st_q.peie;
            end
            ADDR_GLOBAL: rdata_o[GIE_BIT] = st_q.gie;
            default: begin
                for (int i = 0; i < int'(N_CMP); i++) begin
                    if (addr_i == addr_t'(int'(ADDR_CTL_BASE) + i)) begin
                        rdata_o[0] = cmp_s[i];
                    end
                end
            end
        endcase
    end

    assign irq_o = st_q.irq;

    // R8
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(st_q.gie && st_q.peie && |(st_q.flag & st_q.src_en)));

endmodule

// File: tb/test_cmp_change_irq.sv
module test_cmp_change_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp = 2'b00;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cmp_change_irq i_cmp_change_irq (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .cmp_i  (cmp),
        .rd_en_i(rd_en),
        .wr_en_i(wr_en),
        .addr_i (addr),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .irq_o  (irq)
    );

    // Vector: cmp(2) kind(2: 0 none, 1 write, 2 read) addr(3) wdata(8)
    //         exp_flags(2) exp_irq(1) req(4)
    localparam int NVEC = 15;
    localparam logic [21:0] VEC [NVEC] = '{
        {2'b01, 2'd0, 3'd0, 8'h00, 2'b01, 1'b0, 4'd2},  // R2 cmp0 change, enables off
        {2'b01, 2'd1, 3'd0, 8'h00, 2'b00, 1'b0, 4'd3},  // R3 clear by writing 0
        {2'b00, 2'd0, 3'd0, 8'h00, 2'b00, 1'b0, 4'd5},  // R5 return, no refresh
        {2'b01, 2'd0, 3'd0, 8'h00, 2'b01, 1'b0, 4'd2},  // R2 mismatch again
        {2'b01, 2'd1, 3'd0, 8'h00, 2'b00, 1'b0, 4'd3},  // R3 clear
        {2'b01, 2'd2, 3'd3, 8'h00, 2'b00, 1'b0, 4'd6},  // R6 refresh ref0 by read
        {2'b00, 2'd0, 3'd0, 8'h00, 2'b01, 1'b0, 4'd6},  // R6 return now flagged
        {2'b00, 2'd1, 3'd1, 8'h58, 2'b01, 1'b0, 4'd8},  // R8 no global enable
        {2'b00, 2'd1, 3'd2, 8'h80, 2'b01, 1'b1, 4'd8},  // R8 all enables
        {2'b10, 2'd0, 3'd0, 8'h00, 2'b11, 1'b1, 4'd2},  // R2 cmp1 change
        {2'b10, 2'd1, 3'd1, 8'h50, 2'b11, 1'b1, 4'd8},  // R8 only cmp1 enabled
        {2'b10, 2'd1, 3'd0, 8'h08, 2'b01, 1'b0, 4'd8},  // R8 cmp1 cleared
        {2'b10, 2'd1, 3'd0, 8'h18, 2'b11, 1'b1, 4'd3},  // R3 simulated set
        {2'b10, 2'd1, 3'd2, 8'h00, 2'b11, 1'b0, 4'd8},  // R8 global off
        {2'b10, 2'd1, 3'd0, 8'h00, 2'b00, 1'b0, 4'd3}   // R3 clear both
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic access(input bit wr, input logic [2:0] a, input logic [7:0] d);
        wr_en = wr;
        rd_en = !wr;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..all): actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic [21:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4);

        // R1 reset state
        peek(3'd0, d); check("R1 flags", d, 8'h00);
        peek(3'd1, d); check("R1 enable", d, 8'h00);
        peek(3'd2, d); check("R1 global", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        for (int n = 0; n < NVEC; n++) begin
            v   = VEC[n];
            cmp = v[21:20];
            if (v[19:18] == 2'd1) access(1'b1, v[17:15], v[14:7]);
            else if (v[19:18] == 2'd2) access(1'b0, v[17:15], v[14:7]);
            else idle(1);
            idle(3);
            peek(3'd0, d);
            check($sformatf("R%0d flags vec %0d", v[3:0], n), d, {3'b000, v[6:5], 3'b000});
            check($sformatf("R%0d irq vec %0d", v[3:0], n), {7'd0, irq}, {7'd0, v[4]});
        end

        // R9 enable readback and control-register output bit (cmp = 10)
        access(1'b1, 3'd1, 8'h50);
        peek(3'd1, d); check("R9 enable readback", d, 8'h50);
        access(1'b1, 3'd1, 8'hFF);
        peek(3'd1, d); check("R9 unused enable bits", d, 8'h58);
        peek(3'd3, d); check("R9 cmp0 level", d, 8'h00);
        peek(3'd4, d); check("R9 cmp1 level", d, 8'h01);

        // R4 set beats same-edge clear
        access(1'b0, 3'd3, 8'h00);
        access(1'b0, 3'd4, 8'h00);
        idle(2);
        cmp = 2'b11;
        idle(2);
        access(1'b1, 3'd0, 8'h00);   // lands on the flag-setting edge
        idle(2);
        peek(3'd0, d); check("R4 set wins", d, 8'h08);

        // R7 access collides with mismatch rise
        access(1'b1, 3'd0, 8'h00);
        access(1'b0, 3'd3, 8'h00);   // ref0 = 1
        idle(3);
        cmp = 2'b10;
        idle(2);
        access(1'b0, 3'd3, 8'h00);   // same edge as the would-be set
        idle(3);
        peek(3'd0, d); check("R7 collision no flag", d, 8'h00);
        cmp = 2'b11;                 // reference must now be 0
        idle(4);
        peek(3'd0, d); check("R7 reference took new value", d, 8'h08);

        done = 1'b1;
        finish_run();
    end

endmodule